// File: doc/BRIEF.md
# Speculative load tracking table

This block keeps track of loads that a compiler has hoisted above stores that might alias them. When such a load issues, it records its destination register, its byte address and its access size in one of a small set of entries. From then on every store presents its address and size to the table. Any entry whose byte range the store touches is dropped.

Later, a check request names the destination register. If a live entry for that register is still present, the speculation held and the loaded value may be used. If not, the check fails. A mode bit on the request chooses how the failure is reported: either as a request to repeat the load, or as a request to branch to recovery code. A check may also remove its entry on success, and a flush input empties the whole table at once.

All request ports act in a single cycle. The check result is registered and appears one cycle after the request.

Top module: `spec_load_table`

## Requirements
- R1: After a synchronous active-low reset, no entry is live, `chk_resp_valid`, `chk_hit`, `chk_reload` and `chk_recover` are low, and a check of any register fails.
- R2: A check request in cycle n raises `chk_resp_valid` in cycle n+1 together with exactly one of `chk_hit`, `chk_reload`, `chk_recover`. Without a request, all four are low in the next cycle.
- R3: An allocation records register, address and size. A later check of that register hits as long as no store, check-clear or flush has removed it.
- R4: Sizes are encoded as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. A store whose byte range [addr, addr+bytes) shares at least one byte with an entry's range removes that entry. A store that only touches the neighbouring bytes leaves the entry in place.
- R5: A failed check raises `chk_reload` when `chk_mode` is 0 and `chk_recover` when `chk_mode` is 1.
- R6: A hitting check with `chk_clear` = 1 removes its entry, so a following check of that register fails. With `chk_clear` = 0 the entry stays.
- R7: An allocation for a register that already has a live entry overwrites that entry. Only the new address range is then snooped.
- R8: With no same-register entry, an allocation takes the lowest-numbered free entry. When all 8 entries are live, it replaces entries in round-robin order starting at entry 0 after reset.
- R9: When a store overlaps the entry that a check in the same cycle would hit, the store wins: the check fails and the entry is gone.
- R10: `flush` empties every entry in one cycle. A check in the flush cycle fails, and an allocation in the flush cycle is discarded.
- R11: A check sees the table as it stood before the cycle's allocation, so a check in the same cycle as the allocation of its register fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Advanced load allocation request |
| alloc_reg | input | REG_W | Destination register of the advanced load |
| alloc_addr | input | ADDR_W | Byte address of the load |
| alloc_size | input | 2 | Load size code (0:1, 1:2, 2:4, 3:8 bytes) |
| snoop_valid | input | 1 | Store snoop request |
| snoop_addr | input | ADDR_W | Byte address of the store |
| snoop_size | input | 2 | Store size code |
| chk_valid | input | 1 | Check request |
| chk_reg | input | REG_W | Register being checked |
| chk_clear | input | 1 | Remove the entry when the check hits |
| chk_mode | input | 1 | Failure handling: 0 reload, 1 recovery branch |
| flush | input | 1 | Empty the whole table |
| chk_resp_valid | output | 1 | Check result valid (one cycle after request) |
| chk_hit | output | 1 | Speculation held |
| chk_reload | output | 1 | Speculation failed, repeat the load |
| chk_recover | output | 1 | Speculation failed, branch to recovery |

## Verification
Store ranges are placed exactly adjacent below and above a recorded range, and then shifted by a single byte into it. This separates a correct overlap test from an off-by-one comparison, and every size code is exercised. Checks alternate between clearing and non-clearing and between both failure modes, so a swapped mode or a stuck clear shows up. Allocation sequences fill the table with distinct registers, overflow it, and re-use a live register; together these tell same-register replacement apart from free-slot and round-robin victim selection. Same-cycle collisions of store with check, flush with check or allocation, and allocation with check pin down the priority order.

// File: rtl/slt_pkg.sv
// Shared helpers for the speculative load tracking table.
// Assumes size codes 0..3 stand for 1, 2, 4 and 8 bytes.
package slt_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE1 = 2'd0,
        SZ_BYTE2 = 2'd1,
        SZ_BYTE4 = 2'd2,
        SZ_BYTE8 = 2'd3
    } acc_size_e;

    // Width of the size code carried on every request port.
    localparam int unsigned SIZE_W = 2;

endpackage

// File: rtl/slt_range_cmp.sv
// Byte-range overlap test between two accesses.
// Each access is (address, size code); ends are formed one bit wider than
// the address so that ranges touching the top of the space do not wrap.
module slt_range_cmp #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]         a_addr,
    input  logic [slt_pkg::SIZE_W-1:0] a_size,
    input  logic [ADDR_W-1:0]         b_addr,
    input  logic [slt_pkg::SIZE_W-1:0] b_size,
    output logic                      overlap
);
    localparam int unsigned EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;
    logic [EXT_W-1:0] one_ext;

    // Form half-open byte ranges and compare both ends.
    always_comb begin
        one_ext = {{(EXT_W-1){1'b0}}, 1'b1};
        a_lo    = {1'b0, a_addr};
        b_lo    = {1'b0, b_addr};
        a_hi    = a_lo + (one_ext << a_size);
        b_hi    = b_lo + (one_ext << b_size);
        overlap = (a_lo < b_hi) && (b_lo < a_hi);
    end

endmodule

// File: rtl/slt_alloc_select.sv
// Chooses the entry an allocation writes.
// Priority: live entry with the same register, then the lowest free entry,
// then the round-robin victim. Assumes at most one live entry per register.
module slt_alloc_select #(
    parameter int unsigned NUM_ENTRIES = 8,
    localparam int unsigned PTR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [NUM_ENTRIES-1:0] live,
    input  logic [NUM_ENTRIES-1:0] same_reg,
    input  logic [PTR_W-1:0]       rr_ptr,
    output logic [NUM_ENTRIES-1:0] sel,
    output logic                   use_victim
);
    logic found;

    // Walk the three priority levels and produce a one-hot choice.
    always_comb begin
        sel        = '0;
        use_victim = 1'b0;
        found      = 1'b0;
        if (|same_reg) begin
            sel = same_reg;
        end else begin
            for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
                if (!found && !live[i]) begin
                    sel[i] = 1'b1;
                    found  = 1'b1;
                end
            end
            if (!found) begin
                sel[rr_ptr] = 1'b1;
                use_victim  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/spec_load_table.sv
// Speculative load tracking table.
// Records advanced loads by destination register, drops entries hit by
// overlapping stores, answers register-indexed checks one cycle later.
// Update order inside a cycle: flush, then allocation, then store/check
// removal. A check sees the state before the cycle's allocation.
module spec_load_table #(
    parameter int unsigned NUM_ENTRIES = 8,
    parameter int unsigned REG_W       = 7,
    parameter int unsigned ADDR_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [REG_W-1:0]  alloc_reg,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [1:0]        alloc_size,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [1:0]        snoop_size,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic              chk_clear,
    input  logic              chk_mode,
    input  logic              flush,
    output logic              chk_resp_valid,
    output logic              chk_hit,
    output logic              chk_reload,
    output logic              chk_recover
);
    localparam int unsigned PTR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_ENTRIES - 1);

    logic [NUM_ENTRIES-1:0] entry_valid;
    logic [REG_W-1:0]       entry_reg  [NUM_ENTRIES];
    logic [ADDR_W-1:0]      entry_addr [NUM_ENTRIES];
    logic [1:0]             entry_size [NUM_ENTRIES];

    logic [NUM_ENTRIES-1:0] chk_match, alloc_match, store_kill, alloc_sel;
    logic [PTR_W-1:0]       rr_ptr;
    logic                   use_victim;
    logic                   chk_found;

    // Per-entry tag and range comparison plus entry storage.
    for (genvar g = 0; g < int'(NUM_ENTRIES); g++) begin : g_entry
        logic overlap;

        slt_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .a_addr (entry_addr[g]),
            .a_size (entry_size[g]),
            .b_addr (snoop_addr),
            .b_size (snoop_size),
            .overlap(overlap)
        );

        // Tag matches against check and allocation registers, store kill.
        always_comb begin
            chk_match[g]   = entry_valid[g] && (entry_reg[g] == chk_reg);
            alloc_match[g] = entry_valid[g] && (entry_reg[g] == alloc_reg);
            store_kill[g]  = snoop_valid && entry_valid[g] && overlap;
        end

        // Entry update in priority order: flush, allocate, remove.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_valid[g] <= 1'b0;
                entry_reg[g]   <= '0;
                entry_addr[g]  <= '0;
                entry_size[g]  <= '0;
            end else if (flush) begin
                entry_valid[g] <= 1'b0;
            end else if (alloc_valid && alloc_sel[g]) begin
                entry_valid[g] <= 1'b1;
                entry_reg[g]   <= alloc_reg;
                entry_addr[g]  <= alloc_addr;
                entry_size[g]  <= alloc_size;
            end else if (store_kill[g] || (chk_valid && chk_clear && chk_match[g])) begin
                entry_valid[g] <= 1'b0;
            end
        end
    end

    slt_alloc_select #(.NUM_ENTRIES(NUM_ENTRIES)) u_sel (
        .live      (entry_valid),
        .same_reg  (alloc_match),
        .rr_ptr    (rr_ptr),
        .sel       (alloc_sel),
        .use_victim(use_victim)
    );

    // Round-robin victim pointer, advanced only when a victim is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (alloc_valid && !flush && use_victim) begin
            rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
        end
    end

    // A check succeeds only on an entry not killed by a store or flush.
    always_comb begin
        chk_found = chk_valid && !flush && |(chk_match & ~store_kill);
    end

    // Registered check result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_resp_valid <= 1'b0;
            chk_hit        <= 1'b0;
            chk_reload     <= 1'b0;
            chk_recover    <= 1'b0;
        end else begin
            chk_resp_valid <= chk_valid;
            chk_hit        <= chk_found;
            chk_reload     <= chk_valid && !chk_found && !chk_mode;
            chk_recover    <= chk_valid && !chk_found && chk_mode;
        end
    end

endmodule

// File: rtl/slt_checker.sv
// Temporal checks for the speculative load tracking table, attached by bind.
// Assumes a synchronous active-low reset.
module slt_checker #(
    parameter int unsigned NUM_ENTRIES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   chk_valid,
    input logic                   chk_mode,
    input logic                   flush,
    input logic [NUM_ENTRIES-1:0] entry_valid,
    input logic                   chk_resp_valid,
    input logic                   chk_hit,
    input logic                   chk_reload,
    input logic                   chk_recover
);
    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> (chk_resp_valid && $onehot({chk_hit, chk_reload, chk_recover})));

    // R2
    quiet_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !(chk_resp_valid || chk_hit || chk_reload || chk_recover));

    // R5
    fail_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_mode) |=> !chk_recover);

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (entry_valid == '0));

    // R10
    flush_check_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && chk_valid) |=> !chk_hit);

endmodule

bind spec_load_table slt_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_slt_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .chk_valid     (chk_valid),
    .chk_mode      (chk_mode),
    .flush         (flush),
    .entry_valid   (entry_valid),
    .chk_resp_valid(chk_resp_valid),
    .chk_hit       (chk_hit),
    .chk_reload    (chk_reload),
    .chk_recover   (chk_recover)
);

// File: tb/spec_load_table_tb.sv
// Bench for the speculative load tracking table: table walk, then directed.
module spec_load_table_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid, snoop_valid, chk_valid, chk_clear, chk_mode, flush;
    logic [6:0]  alloc_reg, chk_reg;
    logic [31:0] alloc_addr, snoop_addr;
    logic [1:0]  alloc_size, snoop_size;
    logic        chk_resp_valid, chk_hit, chk_reload, chk_recover;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    spec_load_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_reg(alloc_reg),
        .alloc_addr(alloc_addr), .alloc_size(alloc_size),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_size(snoop_size),
        .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_clear(chk_clear),
        .chk_mode(chk_mode), .flush(flush),
        .chk_resp_valid(chk_resp_valid), .chk_hit(chk_hit),
        .chk_reload(chk_reload), .chk_recover(chk_recover)
    );

    // op: 0 allocate, 1 store, 2 check; res: 0 none, 1 hit, 2 reload, 3 recover
    typedef struct packed {
        logic [1:0]  op;
        logic [6:0]  rg;
        logic [31:0] addr;
        logic [1:0]  sz;
        logic        clr;
        logic        mode;
        logic [1:0]  res;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 7'd5, 32'h100, 2'd2, 1'b0, 1'b0, 2'd0}, // R3 allocate r5 0x100..0x103
        '{2'd2, 7'd5, 32'h0,   2'd0, 1'b0, 1'b0, 2'd1}, // R3 hit
        '{2'd1, 7'd0, 32'h104, 2'd0, 1'b0, 1'b0, 2'd0}, // R4 store just above
        '{2'd2, 7'd5, 32'h0,   2'd0, 1'b0, 1'b0, 2'd1},
        '{2'd1, 7'd0, 32'hFE,  2'd1, 1'b0, 1'b0, 2'd0}, // R4 store just below
        '{2'd2, 7'd5, 32'h0,   2'd0, 1'b0, 1'b0, 2'd1},
        '{2'd1, 7'd0, 32'hFF,  2'd1, 1'b0, 1'b0, 2'd0}, // R4 one byte in
        '{2'd2, 7'd5, 32'h0,   2'd0, 1'b0, 1'b0, 2'd2}, // R5 reload
        '{2'd2, 7'd5, 32'h0,   2'd0, 1'b0, 1'b1, 2'd3}, // R5 recover
        '{2'd0, 7'd6, 32'h200, 2'd3, 1'b0, 1'b0, 2'd0}, // R4 8-byte entry
        '{2'd1, 7'd0, 32'h207, 2'd0, 1'b0, 1'b0, 2'd0}, // last byte
        '{2'd2, 7'd6, 32'h0,   2'd0, 1'b0, 1'b0, 2'd2},
        '{2'd0, 7'd7, 32'h300, 2'd0, 1'b0, 1'b0, 2'd0}, // R6
        '{2'd2, 7'd7, 32'h0,   2'd0, 1'b0, 1'b0, 2'd1}, // R6 keep
        '{2'd2, 7'd7, 32'h0,   2'd0, 1'b1, 1'b0, 2'd1}, // R6 clear
        '{2'd2, 7'd7, 32'h0,   2'd0, 1'b0, 1'b1, 2'd3}, // R6 gone
        '{2'd0, 7'd8, 32'h400, 2'd2, 1'b0, 1'b0, 2'd0}, // R7 first range
        '{2'd0, 7'd8, 32'h500, 2'd2, 1'b0, 1'b0, 2'd0}, // R7 replaced range
        '{2'd1, 7'd0, 32'h400, 2'd3, 1'b0, 1'b0, 2'd0}, // R7 old range, no effect
        '{2'd2, 7'd8, 32'h0,   2'd0, 1'b0, 1'b0, 2'd1},
        '{2'd1, 7'd0, 32'h502, 2'd0, 1'b0, 1'b0, 2'd0}  // R7 new range kills
    };

    task automatic idle();
        alloc_valid = 0; alloc_reg = '0; alloc_addr = '0; alloc_size = '0;
        snoop_valid = 0; snoop_addr = '0; snoop_size = '0;
        chk_valid = 0; chk_reg = '0; chk_clear = 0; chk_mode = 0; flush = 0;
    endtask

    function automatic logic [3:0] code_to_bits(input logic [1:0] c);
        return {c != 2'd0, c == 2'd1, c == 2'd2, c == 2'd3};
    endfunction

    task automatic expect_out(input string req, input logic [1:0] exp, input string what);
        logic [3:0] act;
        act = {chk_resp_valid, chk_hit, chk_reload, chk_recover};
        checks++;
        if (act !== code_to_bits(exp)) begin
            fails++;
            $display("FAIL %s %s: {valid,hit,reload,recover} actual %b expected %b",
                     req, what, act, code_to_bits(exp));
        end
    endtask

    // Drive in the current low phase, sample after the next edge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [6:0] r, input logic [31:0] a, input logic [1:0] s);
        idle(); alloc_valid = 1; alloc_reg = r; alloc_addr = a; alloc_size = s;
        step(); idle();
    endtask

    task automatic do_check(input string req, input logic [6:0] r, input logic m,
                            input logic [1:0] exp, input string what);
        idle(); chk_valid = 1; chk_reg = r; chk_mode = m;
        step(); idle();
        expect_out(req, exp, what);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        expect_out("R1", 2'd0, "outputs in reset");
        rst_n = 1;
        step();
        expect_out("R1", 2'd0, "idle after reset");
        do_check("R1", 7'd5, 1'b0, 2'd2, "empty table check");

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            idle();
            case (VECS[i].op)
                2'd0: begin alloc_valid = 1; alloc_reg = VECS[i].rg;
                            alloc_addr = VECS[i].addr; alloc_size = VECS[i].sz; end
                2'd1: begin snoop_valid = 1; snoop_addr = VECS[i].addr;
                            snoop_size = VECS[i].sz; end
                default: begin chk_valid = 1; chk_reg = VECS[i].rg;
                            chk_clear = VECS[i].clr; chk_mode = VECS[i].mode; end
            endcase
            step(); idle();
            expect_out("R2", VECS[i].res, $sformatf("table vector %0d", i));
        end
        do_check("R7", 7'd8, 1'b1, 2'd3, "new range store removed entry");

        // R8: fill, then round-robin victims from entry 0
        idle(); flush = 1; step(); idle();
        for (int r = 1; r <= 8; r++) do_alloc(7'(r), 32'h1000 + 32'(r) * 32'h10, 2'd2);
        do_check("R8", 7'd1, 1'b0, 2'd1, "full table keeps r1");
        do_check("R8", 7'd8, 1'b0, 2'd1, "full table keeps r8");
        do_alloc(7'd9, 32'h2000, 2'd2);
        do_check("R8", 7'd1, 1'b0, 2'd2, "first victim entry 0");
        do_check("R8", 7'd2, 1'b0, 2'd1, "entry 1 untouched");
        do_check("R8", 7'd9, 1'b0, 2'd1, "new entry live");
        do_alloc(7'd10, 32'h2100, 2'd2);
        do_check("R8", 7'd2, 1'b0, 2'd2, "second victim entry 1");
        do_check("R8", 7'd3, 1'b0, 2'd1, "entry 2 untouched");
        // free slot preferred over victim: clear r5 then allocate r11
        idle(); chk_valid = 1; chk_reg = 7'd5; chk_clear = 1; step(); idle();
        do_alloc(7'd11, 32'h2200, 2'd2);
        do_check("R8", 7'd3, 1'b0, 2'd1, "free slot used, r3 kept");
        do_check("R8", 7'd11, 1'b0, 2'd1, "r11 in freed slot");

        // R9: store and check in the same cycle
        idle(); flush = 1; step(); idle();
        do_alloc(7'd20, 32'h800, 2'd2);
        idle(); chk_valid = 1; chk_reg = 7'd20; snoop_valid = 1;
        snoop_addr = 32'h900; snoop_size = 2'd0;
        step(); idle();
        expect_out("R9", 2'd1, "disjoint store with check");
        idle(); chk_valid = 1; chk_reg = 7'd20; snoop_valid = 1;
        snoop_addr = 32'h802; snoop_size = 2'd0;
        step(); idle();
        expect_out("R9", 2'd2, "overlapping store beats check");
        do_check("R9", 7'd20, 1'b0, 2'd2, "entry gone after collision");

        // R11: allocation and check in the same cycle
        idle(); alloc_valid = 1; alloc_reg = 7'd21; alloc_addr = 32'hA00;
        chk_valid = 1; chk_reg = 7'd21; chk_mode = 1;
        step(); idle();
        expect_out("R11", 2'd3, "check misses same-cycle allocation");
        do_check("R11", 7'd21, 1'b0, 2'd1, "allocation visible next cycle");

        // R10: flush priority
        do_alloc(7'd22, 32'hB00, 2'd0);
        idle(); flush = 1; chk_valid = 1; chk_reg = 7'd22;
        step(); idle();
        expect_out("R10", 2'd2, "check in flush cycle fails");
        do_check("R10", 7'd21, 1'b0, 2'd2, "all entries emptied");
        idle(); flush = 1; alloc_valid = 1; alloc_reg = 7'd23; alloc_addr = 32'hC00;
        step(); idle();
        do_check("R10", 7'd23, 1'b1, 2'd3, "allocation in flush cycle dropped");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule